// File: doc/BRIEF.md
# Fractional-Increment Network Time Counter

This block keeps a free-running 64-bit nanosecond count for a network interface. Each time its prescaler fires, the count moves forward by a programmable fixed-point step. The step is a 16-bit integer nanosecond part plus a 32-bit sub-nanosecond part. A 32-bit fraction register holds the sub-nanosecond remainder between steps. When the fraction wraps, the integer count gains one extra nanosecond on that same step. The rate is trimmed only by rewriting the step. Phase corrections are made by software outside the block, so the count itself never jumps except on an explicit load.

Software reaches the block through a write channel and a read channel. Writes to the step and start-time registers only stage a value. Nothing in the counter changes until a self-clearing command word is written. That word has one bit that commits the staged step and another bit that loads the staged start time.

After a step commit, the write channel holds itself off for a fixed number of cycles, so the step registers cannot change under the counter while the new value settles. The write channel uses valid/ready, and a write is taken in a cycle where both are high. The read channel never stalls: `rd_req_ready` is always high. Every read request gets its response exactly one cycle later, and that response has no back-pressure. The count is read as two 32-bit halves. A reader who needs a coherent 64-bit value reads high, then low, then high again, and repeats the three reads if the two high values differ.

Top module: `ptp_hw_clock`

## Requirements
- R1: After reset the block is in this state:
  - the count is 0 and the counter is disabled;
  - `wr_ready` is 1;
  - the active and staged steps both equal the nominal step for a 600 MHz tick, integer 1 and fraction 0xAAAAAAAA;
  - the control word at address 0 reads 0x310.
- R2: On every prescaler tick the count advances by the active Q16.32 step. The carry out of the 32-bit fraction adds 1 ns on the same tick. T ticks after a load, the count equals start + floor(T * step / 2^32).
- R3: Writing the staged step has no effect on counting until the commit bit is written. The staged integer part is at address 1, bits [15:0]. The staged fraction is at address 2. The commit bit is bit 0 of the command word at address 5. Staged values read back at their own addresses.
- R4: Command bit 1 loads {start-high (address 3), start-low (address 4)} into the count and clears the fraction. When bits 0 and 1 are written together, the committed step is the one used from the loaded start onward.
- R5: When a write that commits a step is accepted, `wr_ready` is low for the next 4 cycles and then high again.
- R6: The counter advances only while control bit 0 (enable) is 1. It then advances once every N cycles, where N is control bits [7:4]; the value 0 acts as 1. While disabled, the count stays frozen.
- R7: `mac_strobe` is a one-cycle pulse that follows every (M+1)-th tick, where M is control bits [11:8]. It only fires while control bit 1 is set. Its phase restarts on a start-time load.
- R8:
  - Address 6 returns the count's upper word and address 7 returns its lower word.
  - `rd_rsp_valid` rises the cycle after a request.
  - The command word always reads 0.
- R9: A high, low, high read sequence with retry on mismatch returns a 64-bit value that lies between the count seen before the sequence and the count seen after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write channel accepts; low during the post-commit hold |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Always 1; reads never stall |
| rd_addr | input | 3 | Read register address |
| rd_rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| time_ns | output | 64 | Current nanosecond count |
| tick_pulse | output | 1 | High in cycles where the count advances by a step |
| mac_strobe | output | 1 | Divided timing strobe for the MAC |

## Verification
The bench builds the block with its default widths: a 16-bit integer step, a 32-bit fraction, 4-bit interval fields and a 4-cycle hold. These values keep every interval setting small enough to sweep. The sweep crosses the tick interval 0 to 3 with five steps and two run lengths. The five steps are the nominal one, exact 1 ns, just under 1 ns, 3.5 ns and one sub-nanosecond unit. The MAC divider value rotates through 0 to 3 across the runs. Together these cover fractional carries on every tick, no carries at all, and the rounding of the nominal step. A staged-only rewrite, the hold window and a coherent read across a 32-bit word boundary are each driven once.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  typedef enum logic [2:0] {
    A_CTRL     = 3'd0,
    A_INC_NS   = 3'd1,
    A_INC_FRAC = 3'd2,
    A_INIT_HI  = 3'd3,
    A_INIT_LO  = 3'd4,
    A_CMD      = 3'd5,
    A_CNT_HI   = 3'd6,
    A_CNT_LO   = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TSO_BIT  = 1;
  localparam int CTRL_TICK_LSB = 4;
  localparam int CTRL_MAC_LSB  = 8;
  localparam int CMD_SET_BIT   = 0;
  localparam int CMD_LOAD_BIT  = 1;
endpackage

// File: rtl/ptp_clk_regs.sv
module ptp_clk_regs
  import ptp_clk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 32,
  parameter int IVAL_W   = 4,
  parameter int HOLD_CYC = 4,
  parameter logic [INT_W-1:0]  RST_INC_NS    = '0,
  parameter logic [FRAC_W-1:0] RST_INC_FRAC  = '0,
  parameter logic [IVAL_W-1:0] RST_TICK_IVAL = 1,
  parameter logic [IVAL_W-1:0] RST_MAC_IVAL  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_req_valid,
  input  logic [2:0]          rd_addr,
  output logic                rd_rsp_valid,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [2*DATA_W-1:0] count,
  output logic                ctrl_en,
  output logic                ctrl_tso,
  output logic [IVAL_W-1:0]   tick_ival,
  output logic [IVAL_W-1:0]   mac_ival,
  output logic [INT_W-1:0]    act_inc_ns,
  output logic [FRAC_W-1:0]   act_inc_frac,
  output logic                set_pulse,
  output logic                load_pulse,
  output logic [2*DATA_W-1:0] init_val
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [INT_W-1:0]  stg_ns;
  logic [FRAC_W-1:0] stg_frac;
  logic [DATA_W-1:0] init_hi, init_lo;
  logic [HOLD_W-1:0] hold_cnt;
  logic              wr_fire;
  logic              cmd_hit;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ready   = (hold_cnt == '0);
  assign wr_fire    = wr_valid && wr_ready;
  assign cmd_hit    = wr_fire && (reg_addr_e'(wr_addr) == A_CMD);
  assign set_pulse  = cmd_hit && wr_data[CMD_SET_BIT];
  assign load_pulse = cmd_hit && wr_data[CMD_LOAD_BIT];
  assign init_val   = {init_hi, init_lo};

  // staging registers and control word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_tso  <= 1'b0;
      tick_ival <= RST_TICK_IVAL;
      mac_ival  <= RST_MAC_IVAL;
      stg_ns    <= RST_INC_NS;
      stg_frac  <= RST_INC_FRAC;
      init_hi   <= '0;
      init_lo   <= '0;
    end else if (wr_fire) begin
      case (reg_addr_e'(wr_addr))
        A_CTRL: begin
          ctrl_en   <= wr_data[CTRL_EN_BIT];
          ctrl_tso  <= wr_data[CTRL_TSO_BIT];
          tick_ival <= wr_data[CTRL_TICK_LSB +: IVAL_W];
          mac_ival  <= wr_data[CTRL_MAC_LSB +: IVAL_W];
        end
        A_INC_NS:   stg_ns   <= wr_data[INT_W-1:0];
        A_INC_FRAC: stg_frac <= wr_data[FRAC_W-1:0];
        A_INIT_HI:  init_hi  <= wr_data;
        A_INIT_LO:  init_lo  <= wr_data;
        default: ;
      endcase
    end
  end

  // active step, changed only by the commit command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_inc_ns   <= RST_INC_NS;
      act_inc_frac <= RST_INC_FRAC;
    end else if (set_pulse) begin
      act_inc_ns   <= stg_ns;
      act_inc_frac <= stg_frac;
    end
  end

  // post-commit write hold-off
  always_ff @(posedge clk) begin
    if (!rst_n)              hold_cnt <= '0;
    else if (set_pulse)      hold_cnt <= HOLD_W'(HOLD_CYC);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL: begin
        rd_mux[CTRL_EN_BIT]                = ctrl_en;
        rd_mux[CTRL_TSO_BIT]               = ctrl_tso;
        rd_mux[CTRL_TICK_LSB +: IVAL_W]    = tick_ival;
        rd_mux[CTRL_MAC_LSB +: IVAL_W]     = mac_ival;
      end
      A_INC_NS:   rd_mux[INT_W-1:0]  = stg_ns;
      A_INC_FRAC: rd_mux[FRAC_W-1:0] = stg_frac;
      A_INIT_HI:  rd_mux = init_hi;
      A_INIT_LO:  rd_mux = init_lo;
      A_CNT_HI:   rd_mux = count[2*DATA_W-1:DATA_W];
      A_CNT_LO:   rd_mux = count[DATA_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_data      <= '0;
    end else begin
      rd_rsp_valid <= rd_req_valid;
      if (rd_req_valid) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ptp_clk_ticker.sv
module ptp_clk_ticker #(
  parameter int IVAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tso_en,
  input  logic [IVAL_W-1:0] tick_ival,
  input  logic [IVAL_W-1:0] mac_ival,
  input  logic              load,
  output logic              tick,
  output logic              mac_strobe
);
  logic [IVAL_W-1:0] pre_cnt;
  logic [IVAL_W-1:0] ival_eff;
  logic [IVAL_W-1:0] mac_cnt;
  logic              mac_wrap;

  assign ival_eff = (tick_ival == '0) ? IVAL_W'(1) : tick_ival;
  assign tick     = enable && (pre_cnt == ival_eff - 1'b1);
  assign mac_wrap = (mac_cnt == mac_ival);

  always_ff @(posedge clk) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (!enable || tick)  pre_cnt <= '0;
    else                       pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mac_cnt    <= '0;
      mac_strobe <= 1'b0;
    end else begin
      mac_strobe <= tick && mac_wrap && tso_en;
      if (load)      mac_cnt <= '0;
      else if (tick) mac_cnt <= mac_wrap ? '0 : mac_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_clk_accum.sv
module ptp_clk_accum #(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [CNT_W-1:0]  init_val,
  input  logic [INT_W-1:0]  inc_ns,
  input  logic [FRAC_W-1:0] inc_frac,
  output logic [CNT_W-1:0]  count
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;

  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      frac_q <= '0;
    end else if (load) begin
      count  <= init_val;
      frac_q <= '0;
    end else if (tick) begin
      frac_q <= frac_sum[FRAC_W-1:0];
      count  <= count + CNT_W'(inc_ns) + CNT_W'(frac_sum[FRAC_W]);
    end
  end
endmodule

// File: rtl/ptp_hw_clock.sv
module ptp_hw_clock
  import ptp_clk_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          INT_W    = 16,
  parameter int          FRAC_W   = 32,
  parameter int          IVAL_W   = 4,
  parameter int          HOLD_CYC = 4,
  parameter longint      TICK_HZ  = 600_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  input  logic [2:0]          rd_addr,
  output logic                rd_rsp_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] time_ns,
  output logic                tick_pulse,
  output logic                mac_strobe
);
  localparam int          CNT_W   = 2 * DATA_W;
  localparam logic [95:0] NOM_Q   = (96'd1_000_000_000 << FRAC_W) / 96'(TICK_HZ);
  localparam logic [INT_W-1:0]  NOM_NS   = NOM_Q[FRAC_W +: INT_W];
  localparam logic [FRAC_W-1:0] NOM_FRAC = NOM_Q[FRAC_W-1:0];

  logic              ctrl_en, ctrl_tso;
  logic [IVAL_W-1:0] tick_ival, mac_ival;
  logic [INT_W-1:0]  act_inc_ns;
  logic [FRAC_W-1:0] act_inc_frac;
  logic              set_pulse, load_pulse, tick;
  logic [CNT_W-1:0]  init_val;

  assign rd_req_ready = 1'b1;
  assign tick_pulse   = tick;

  ptp_clk_regs #(
    .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .IVAL_W(IVAL_W),
    .HOLD_CYC(HOLD_CYC), .RST_INC_NS(NOM_NS), .RST_INC_FRAC(NOM_FRAC),
    .RST_TICK_IVAL(IVAL_W'(1)), .RST_MAC_IVAL(IVAL_W'(3))
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_data(rd_data),
    .count(time_ns),
    .ctrl_en(ctrl_en), .ctrl_tso(ctrl_tso), .tick_ival(tick_ival), .mac_ival(mac_ival),
    .act_inc_ns(act_inc_ns), .act_inc_frac(act_inc_frac),
    .set_pulse(set_pulse), .load_pulse(load_pulse), .init_val(init_val)
  );

  ptp_clk_ticker #(.IVAL_W(IVAL_W)) u_ticker (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_en), .tso_en(ctrl_tso),
    .tick_ival(tick_ival), .mac_ival(mac_ival), .load(load_pulse),
    .tick(tick), .mac_strobe(mac_strobe)
  );

  ptp_clk_accum #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_pulse),
    .init_val(init_val), .inc_ns(act_inc_ns), .inc_frac(act_inc_frac),
    .count(time_ns)
  );
endmodule

// File: rtl/ptp_hw_clock_chk.sv
module ptp_hw_clock_chk #(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [2:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_req_valid,
  input logic              rd_rsp_valid,
  input logic [CNT_W-1:0]  time_ns,
  input logic              tick,
  input logic              load_pulse,
  input logic [CNT_W-1:0]  init_val,
  input logic [INT_W-1:0]  act_inc_ns,
  input logic [FRAC_W-1:0] act_inc_frac,
  input logic              ctrl_en
);
  AST_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == 3'd5 && wr_data[0]) |=> !wr_ready); // R5

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !load_pulse) |=> $stable(time_ns)); // R6

  AST_TICK_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_en); // R6

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_pulse) |=>
      ((time_ns - $past(time_ns) - CNT_W'($past(act_inc_ns))) <= CNT_W'(1))); // R2

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (time_ns == $past(init_val))); // R4

  AST_RD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> rd_rsp_valid); // R8

  AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready && wr_addr == 3'd5 && wr_data[0])
      |=> ($stable(act_inc_ns) && $stable(act_inc_frac))); // R3
endmodule

bind ptp_hw_clock ptp_hw_clock_chk #(
  .CNT_W(2*DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_req_valid(rd_req_valid),
  .rd_rsp_valid(rd_rsp_valid), .time_ns(time_ns), .tick(tick),
  .load_pulse(load_pulse), .init_val(init_val), .act_inc_ns(act_inc_ns),
  .act_inc_frac(act_inc_frac), .ctrl_en(ctrl_en)
);

// File: tb/ptp_hw_clock_test.sv
`timescale 1ns/1ps
module ptp_hw_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_req_valid = 1'b0;
  logic        rd_req_ready;
  logic [2:0]  rd_addr = '0;
  logic        rd_rsp_valid;
  logic [31:0] rd_data;
  logic [63:0] time_ns;
  logic        tick_pulse;
  logic        mac_strobe;

  int checks = 0;
  int errors = 0;
  int tick_seen = 0;
  int strobe_seen = 0;

  always #5 clk = ~clk;

  ptp_hw_clock uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_data(rd_data), .time_ns(time_ns), .tick_pulse(tick_pulse),
    .mac_strobe(mac_strobe)
  );

  always @(negedge clk) begin
    if (tick_pulse) tick_seen++;
    if (mac_strobe) strobe_seen++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_req_valid = 1'b0;
    @(negedge clk);
    chk("R8 rsp_valid", 64'(rd_rsp_valid), 64'd1);
    d = rd_data;
  endtask

  // enable for exactly k clock edges, then disable
  task automatic run(input int p, input int m, input int k);
    wr(3'd0, 32'h1 | 32'h2 | (32'(p) << 4) | (32'(m) << 8));
    repeat (k - 1) @(posedge clk);
    wr(3'd0, (32'(p) << 4) | (32'(m) << 8));
    @(negedge clk); @(negedge clk);
  endtask

  task automatic load(input logic [63:0] st, input logic [15:0] ns, input logic [31:0] fr);
    wr(3'd3, st[63:32]); wr(3'd4, st[31:0]);
    wr(3'd1, 32'(ns));   wr(3'd2, fr);
    wr(3'd5, 32'h3);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, h1, l, h2;
    logic [47:0] incs [5];
    logic [63:0] exp, t0, t1, v;
    int t_before, s_before;
    incs[0] = 48'h1_AAAA_AAAA; incs[1] = 48'h1_0000_0000; incs[2] = 48'h0_FFFF_FFFF;
    incs[3] = 48'h3_8000_0000; incs[4] = 48'h0_0000_0001;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", time_ns, 64'd0);
    chk("R1 wr_ready", 64'(wr_ready), 64'd1);
    rd(3'd1, d); chk("R1 staged int", 64'(d), 64'd1);
    rd(3'd2, d); chk("R1 staged frac", 64'(d), 64'hAAAAAAAA);
    rd(3'd0, d); chk("R1 ctrl", 64'(d), 64'h310);
    run(1, 3, 6);
    chk("R1 nominal step", time_ns, (64'd6 * 64'h1_AAAA_AAAA) >> 32);

    // R2 R6 R7 sweep over interval, step and run length
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 5; i++) begin
        for (int r = 0; r < 2; r++) begin
          int k, pe, tk, m;
          logic [63:0] st;
          k  = (r == 0) ? 7 : 20;
          pe = (p == 0) ? 1 : p;
          tk = k / pe;
          m  = (p + i + r) % 4;
          st = 64'h0000_0001_0000_0000 + 64'(i * 1000 + p);
          load(st, incs[i][47:32], incs[i][31:0]);
          chk("R4 load", time_ns, st);
          t_before = tick_seen; s_before = strobe_seen;
          run(p, m, k);
          exp = st + ((64'(tk) * 64'(incs[i])) >> 32);
          chk("R2 accumulate", time_ns, exp);
          chk("R6 tick count", 64'(tick_seen - t_before), 64'(tk));
          chk("R7 strobe count", 64'(strobe_seen - s_before), 64'(tk / (m + 1)));
        end
      end
    end

    // R6 frozen while disabled
    t0 = time_ns;
    repeat (10) @(negedge clk);
    chk("R6 frozen", time_ns, t0);

    // R7 no strobe with output enable clear
    load(64'd0, 16'd1, 32'd0);
    s_before = strobe_seen;
    wr(3'd0, 32'h1 | (32'd1 << 4));
    repeat (9) @(posedge clk);
    wr(3'd0, 32'd1 << 4);
    @(negedge clk); @(negedge clk);
    chk("R7 gated", 64'(strobe_seen - s_before), 64'd0);

    // R3 staged step has no effect until commit
    load(64'd0, 16'd2, 32'd0);
    wr(3'd1, 32'd7); wr(3'd2, 32'h8000_0000);
    wr(3'd3, 32'd0); wr(3'd4, 32'd100);
    wr(3'd5, 32'h2);
    @(negedge clk);
    chk("R4 init only", time_ns, 64'd100);
    run(1, 0, 10);
    chk("R3 old step kept", time_ns, 64'd120);
    rd(3'd1, d); chk("R3 staged readback", 64'(d), 64'd7);
    // R5 hold window after commit
    wr(3'd5, 32'h1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R5 hold", 64'(wr_ready), (c < 4) ? 64'd0 : 64'd1);
    end
    run(1, 0, 10);
    chk("R3 new step", time_ns, 64'd195);

    // R8 word readout
    load(64'h1234_5678_9ABC_DEF0, 16'd1, 32'd0);
    rd(3'd6, d); chk("R8 hi", 64'(d), 64'h1234_5678);
    rd(3'd7, d); chk("R8 lo", 64'(d), 64'h9ABC_DEF0);
    rd(3'd5, d); chk("R8 cmd reads 0", 64'(d), 64'd0);

    // R9 coherent read across the low word wrap
    load(64'h0000_0002_FFFF_FFF0, 16'd1, 32'd0);
    wr(3'd0, 32'h1 | (32'd1 << 4));
    @(negedge clk);
    t0 = time_ns;
    h1 = 32'd0; h2 = 32'd1; l = 32'd0;
    for (int tries = 0; tries < 8 && h1 != h2; tries++) begin
      rd(3'd6, h1); rd(3'd7, l); rd(3'd6, h2);
    end
    @(negedge clk);
    t1 = time_ns;
    wr(3'd0, 32'd1 << 4);
    v = {h1, l};
    chk("R9 coherent", 64'((h1 == h2) && (v >= t0) && (v <= t1)), 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule